// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block consumes a circular chain of transmit descriptors that sit in a small on-chip descriptor memory. Software fills descriptors through a plain write port, gives each one to the engine by setting its ownership flag, and then strobes a start input. The engine follows the chain from the current position. For each descriptor it owns, it presents the buffer address and byte count to a packet sink and waits for the sink to finish. It then rewrites the command word in place with the completion status, clearing the ownership flag in the same write, and moves on along the link field.

When the engine reaches a descriptor it does not own, it stops and gives a one-cycle idle pulse. It then waits for the next start strobe, and on that strobe it fetches the same descriptor again. Per-descriptor pulses report a good frame, an errored frame, and a completion interrupt that the descriptor can request. A descriptor holds four 32-bit words. Word 0 is the link (the index of the next descriptor, in its low bits). Word 1 is command/status. Word 2 is the buffer address. Word 3 is for software only. Descriptor `i` occupies words `4*i` to `4*i+3`.

Top module: `txr_ring_walker`

## Requirements
- R1: After reset, `busy`, `pkt_valid`, `tx_idle`, `tx_ok`, `tx_err` and `irq_desc` are all low and the engine waits for a start strobe.
- R2: While the engine is stopped, a `tx_enable` strobe starts a fetch at the current descriptor index. A `base_we` pulse sets that index, so a later strobe starts there. `busy` is high from the cycle after the strobe until the engine stops.
- R3: A descriptor whose word-1 bit 31 (ownership) is set is presented with `pkt_valid` high two cycles after the engine reaches it. The outputs are `pkt_addr` = word 2, `pkt_len` = word-1 bits 11:0, and `pkt_more` = word-1 bit 30. These outputs are held unchanged until the cycle in which `sink_done` is high.
- R4: When `sink_done` is seen, word 1 is rewritten as follows. Bit 31 is cleared. Bits 30:28 and 15:0 are kept. Bits 27:20 take `sink_flags[7:0]`: ok=27, abort=26, underrun=25, carrier lost=24, deferred=23, excessive deferral=22, late collision=21, excessive collisions=20. Bits 19:16 take `sink_coll`.
- R5: After a completion, the engine fetches the descriptor named by the link field. A link from the last descriptor back to the first closes the ring, and the walk wraps through it.
- R6: Fetching a descriptor with bit 31 clear stops the walk. `tx_idle` pulses for one cycle and `busy` falls. The next strobe fetches that same descriptor again.
- R7: `irq_desc` pulses for one cycle, in the cycle after `sink_done`, exactly when the completed descriptor had word-1 bit 29 set.
- R8: In the cycle after `sink_done`, `tx_ok` pulses when `sink_flags[7]` is set. `tx_err` pulses when any of `sink_flags[6:4]` or `sink_flags[2:0]` is set. A deferred-only status (`sink_flags[3]`) raises neither.
- R9: `tx_enable` and `base_we` have no effect while the engine is busy.
- R10: The engine never writes words 0, 2 or 3 of a descriptor, and it never writes a descriptor it does not own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_we | input | 1 | Host write strobe into descriptor memory |
| host_waddr | input | 6 | Host write word address |
| host_wdata | input | 32 | Host write data |
| host_raddr | input | 6 | Host read word address |
| host_rdata | output | 32 | Host read data (combinational) |
| base_we | input | 1 | Load the start descriptor index |
| base_idx | input | 4 | Start descriptor index |
| tx_enable | input | 1 | Start/restart strobe |
| pkt_valid | output | 1 | Descriptor presented to the sink |
| pkt_addr | output | 32 | Buffer address |
| pkt_len | output | 12 | Buffer length in bytes |
| pkt_more | output | 1 | Frame continues in the next descriptor |
| sink_done | input | 1 | Sink finished the presented descriptor |
| sink_flags | input | 8 | Completion flags, bit 7 ok down to bit 0 excessive collisions |
| sink_coll | input | 4 | Collision count |
| busy | output | 1 | Engine is walking the ring |
| tx_idle | output | 1 | One-cycle pulse on stopping |
| tx_ok | output | 1 | One-cycle good-completion pulse |
| tx_err | output | 1 | One-cycle error-completion pulse |
| irq_desc | output | 1 | One-cycle requested-interrupt pulse |

## Verification
The assertions assume that the sink raises `sink_done` only while `pkt_valid` is high, and for a single cycle per descriptor. The bench sink meets this: it counts a latency from `pkt_valid`, pulses `sink_done` once, and drops it before the next descriptor is presented. The assertions also assume that the host does not write the command word of the descriptor being fetched or completed in that same cycle. The stimulus respects this by writing descriptors only while the engine is stopped, or while it is waiting on a different descriptor.

// File: rtl/txr_pkg.sv
package txr_pkg;
    localparam int OWN_BIT  = 31;
    localparam int MORE_BIT = 30;
    localparam int INTR_BIT = 29;
    localparam int LEN_W    = 12;
    localparam int FLAG_LSB = 20;
    localparam int COLL_LSB = 16;
    localparam int FLAG_W   = 8;
    localparam int COLL_W   = 4;
    localparam int FLAG_OK  = 7;
    // bits of the command word that survive write-back
    localparam logic [31:0] KEEP_MASK = 32'h7000_FFFF;
    // abort, underrun, carrier, excessive deferral, late and excessive collision
    localparam logic [FLAG_W-1:0] ERR_MASK = 8'b0111_0111;
    // word offsets inside a descriptor
    localparam logic [1:0] W_LINK = 2'd0;
    localparam logic [1:0] W_CMD  = 2'd1;
    localparam logic [1:0] W_BUF  = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SEND  = 2'd2
    } walk_st_e;
endpackage

// File: rtl/txr_desc_ram.sv
module txr_desc_ram
    import txr_pkg::*;
#(
    parameter int N_DESC = 16,
    localparam int DIDX_W = $clog2(N_DESC),
    localparam int AW = DIDX_W + 2,
    localparam int WORDS = N_DESC * 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [AW-1:0]     host_waddr,
    input  logic [31:0]       host_wdata,
    input  logic [AW-1:0]     host_raddr,
    output logic [31:0]       host_rdata,
    input  logic [DIDX_W-1:0] rd_idx,
    output logic [DIDX_W-1:0] rd_link,
    output logic [31:0]       rd_cmd,
    output logic [31:0]       rd_buf,
    input  logic              eng_we,
    input  logic [AW-1:0]     eng_waddr,
    input  logic [31:0]       eng_wdata
);
    logic [31:0] mem_q [WORDS];
    logic [31:0] link_word;

    always_ff @(posedge clk) begin
        if (host_we && !(eng_we && (eng_waddr == host_waddr)))
            mem_q[host_waddr] <= host_wdata;
        if (eng_we)
            mem_q[eng_waddr] <= eng_wdata;
    end

    always_comb begin
        link_word  = mem_q[{rd_idx, W_LINK}];
        rd_link    = link_word[DIDX_W-1:0];
        rd_cmd     = mem_q[{rd_idx, W_CMD}];
        rd_buf     = mem_q[{rd_idx, W_BUF}];
        host_rdata = mem_q[host_raddr];
    end

    // engine only ever touches command words and always hands them back
    assert_wb_cmd_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |-> (eng_waddr[1:0] == W_CMD));
    assert_wb_owner_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |-> !eng_wdata[OWN_BIT]);
endmodule

// File: rtl/txr_status_merge.sv
module txr_status_merge
    import txr_pkg::*;
(
    input  logic [31:0]       cmd,
    input  logic [FLAG_W-1:0] flags,
    input  logic [COLL_W-1:0] coll,
    output logic [31:0]       wb_word,
    output logic              wb_ok,
    output logic              wb_err
);
    always_comb begin
        wb_word = (cmd & KEEP_MASK)
                | (32'(flags) << FLAG_LSB)
                | (32'(coll)  << COLL_LSB);
        wb_ok   = flags[FLAG_OK];
        wb_err  = |(flags & ERR_MASK);
    end
endmodule

// File: rtl/txr_walker_fsm.sv
module txr_walker_fsm
    import txr_pkg::*;
#(
    parameter int DIDX_W = 4,
    localparam int AW = DIDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_enable,
    input  logic              base_we,
    input  logic [DIDX_W-1:0] base_idx,
    output logic [DIDX_W-1:0] rd_idx,
    input  logic [DIDX_W-1:0] rd_link,
    input  logic [31:0]       rd_cmd,
    input  logic [31:0]       rd_buf,
    input  logic              sink_done,
    output logic [31:0]       cur_cmd,
    input  logic [31:0]       wb_word,
    input  logic              wb_ok,
    input  logic              wb_err,
    output logic              eng_we,
    output logic [AW-1:0]     eng_waddr,
    output logic [31:0]       eng_wdata,
    output logic              pkt_valid,
    output logic [31:0]       pkt_addr,
    output logic [LEN_W-1:0]  pkt_len,
    output logic              pkt_more,
    output logic              busy,
    output logic              tx_idle,
    output logic              tx_ok,
    output logic              tx_err,
    output logic              irq_desc
);
    typedef struct packed {
        walk_st_e          state;
        logic [DIDX_W-1:0] cur;
        logic [DIDX_W-1:0] nxt;
        logic [31:0]       cmd;
        logic [31:0]       bufa;
        logic              idle;
        logic              ok;
        logic              err;
        logic              irq;
    } walk_t;

    walk_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.idle = 1'b0;
        r_d.ok   = 1'b0;
        r_d.err  = 1'b0;
        r_d.irq  = 1'b0;
        eng_we   = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (base_we)   r_d.cur   = base_idx;
                if (tx_enable) r_d.state = ST_FETCH;
            end
            ST_FETCH: begin
                if (!rd_cmd[OWN_BIT]) begin
                    r_d.state = ST_IDLE;
                    r_d.idle  = 1'b1;
                end else begin
                    r_d.cmd   = rd_cmd;
                    r_d.bufa  = rd_buf;
                    r_d.nxt   = rd_link;
                    r_d.state = ST_SEND;
                end
            end
            ST_SEND: begin
                if (sink_done) begin
                    eng_we    = 1'b1;
                    r_d.cur   = r_q.nxt;
                    r_d.state = ST_FETCH;
                    r_d.ok    = wb_ok;
                    r_d.err   = wb_err;
                    r_d.irq   = r_q.cmd[INTR_BIT];
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    always_comb begin
        rd_idx    = r_q.cur;
        cur_cmd   = r_q.cmd;
        eng_waddr = {r_q.cur, W_CMD};
        eng_wdata = wb_word;
        pkt_valid = (r_q.state == ST_SEND);
        pkt_addr  = r_q.bufa;
        pkt_len   = r_q.cmd[LEN_W-1:0];
        pkt_more  = r_q.cmd[MORE_BIT];
        busy      = (r_q.state != ST_IDLE);
        tx_idle   = r_q.idle;
        tx_ok     = r_q.ok;
        tx_err    = r_q.err;
        irq_desc  = r_q.irq;
    end

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && tx_enable) |=> busy);
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !sink_done) |=> (pkt_valid && $stable(pkt_addr) && $stable(pkt_len)));
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> (!busy && !pkt_valid));
    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_desc |-> $past(pkt_valid && sink_done));
    assert_status_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ok || tx_err) |-> $past(pkt_valid && sink_done));
endmodule

// File: rtl/txr_ring_walker.sv
module txr_ring_walker
    import txr_pkg::*;
#(
    parameter int N_DESC = 16,
    localparam int DIDX_W = $clog2(N_DESC),
    localparam int AW = DIDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [AW-1:0]     host_waddr,
    input  logic [31:0]       host_wdata,
    input  logic [AW-1:0]     host_raddr,
    output logic [31:0]       host_rdata,
    input  logic              base_we,
    input  logic [DIDX_W-1:0] base_idx,
    input  logic              tx_enable,
    output logic              pkt_valid,
    output logic [31:0]       pkt_addr,
    output logic [LEN_W-1:0]  pkt_len,
    output logic              pkt_more,
    input  logic              sink_done,
    input  logic [FLAG_W-1:0] sink_flags,
    input  logic [COLL_W-1:0] sink_coll,
    output logic              busy,
    output logic              tx_idle,
    output logic              tx_ok,
    output logic              tx_err,
    output logic              irq_desc
);
    logic [DIDX_W-1:0] rd_idx, rd_link;
    logic [31:0]       rd_cmd, rd_buf, cur_cmd, wb_word, eng_wdata;
    logic              wb_ok, wb_err, eng_we;
    logic [AW-1:0]     eng_waddr;

    txr_desc_ram #(.N_DESC(N_DESC)) u_ram (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_waddr (host_waddr),
        .host_wdata (host_wdata),
        .host_raddr (host_raddr),
        .host_rdata (host_rdata),
        .rd_idx     (rd_idx),
        .rd_link    (rd_link),
        .rd_cmd     (rd_cmd),
        .rd_buf     (rd_buf),
        .eng_we     (eng_we),
        .eng_waddr  (eng_waddr),
        .eng_wdata  (eng_wdata)
    );

    txr_status_merge u_merge (
        .cmd     (cur_cmd),
        .flags   (sink_flags),
        .coll    (sink_coll),
        .wb_word (wb_word),
        .wb_ok   (wb_ok),
        .wb_err  (wb_err)
    );

    txr_walker_fsm #(.DIDX_W(DIDX_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_enable (tx_enable),
        .base_we   (base_we),
        .base_idx  (base_idx),
        .rd_idx    (rd_idx),
        .rd_link   (rd_link),
        .rd_cmd    (rd_cmd),
        .rd_buf    (rd_buf),
        .sink_done (sink_done),
        .cur_cmd   (cur_cmd),
        .wb_word   (wb_word),
        .wb_ok     (wb_ok),
        .wb_err    (wb_err),
        .eng_we    (eng_we),
        .eng_waddr (eng_waddr),
        .eng_wdata (eng_wdata),
        .pkt_valid (pkt_valid),
        .pkt_addr  (pkt_addr),
        .pkt_len   (pkt_len),
        .pkt_more  (pkt_more),
        .busy      (busy),
        .tx_idle   (tx_idle),
        .tx_ok     (tx_ok),
        .tx_err    (tx_err),
        .irq_desc  (irq_desc)
    );
endmodule

// File: tb/txr_ring_walker_bench.sv
module txr_ring_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [5:0]  host_waddr = '0;
    logic [31:0] host_wdata = '0;
    logic [5:0]  host_raddr = '0;
    logic [31:0] host_rdata;
    logic        base_we = 1'b0;
    logic [3:0]  base_idx = '0;
    logic        tx_enable = 1'b0;
    logic        pkt_valid, pkt_more, busy, tx_idle, tx_ok, tx_err, irq_desc;
    logic [31:0] pkt_addr;
    logic [11:0] pkt_len;
    logic        sink_done = 1'b0;
    logic [7:0]  sink_flags = '0;
    logic [3:0]  sink_coll = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    bit running = 1'b0;

    always #5 clk = ~clk;

    txr_ring_walker u_txr_ring_walker (.*);

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] wb(input logic [31:0] c, input logic [7:0] f, input logic [3:0] k);
        return {1'b0, c[30:28], f, k, c[15:0]};
    endfunction

    // ---------------- sink stub ----------------
    logic [7:0] rsp_flags [16];
    logic [3:0] rsp_coll  [16];
    int         rsp_lat   [16];
    int         rptr = 0;
    int         scnt = 0;

    always @(negedge clk) begin
        if (sink_done) begin
            sink_done = 1'b0;
            scnt = 0;
        end else if (pkt_valid) begin
            if (scnt >= rsp_lat[rptr]) begin
                sink_done  = 1'b1;
                sink_flags = rsp_flags[rptr];
                sink_coll  = rsp_coll[rptr];
                rptr++;
                scnt = 0;
            end else scnt++;
        end
    end

    // ---------------- behavioural reference ----------------
    int          ms = 0;               // 0 stopped, 1 fetching, 2 presenting
    logic [3:0]  mcur = '0, mnext = '0;
    logic [31:0] mcmd = '0, maddr = '0;
    logic [31:0] mm [64];
    bit          m_idle = 0, m_ok = 0, m_err = 0, m_irq = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ms <= 0; mcur <= '0; m_idle <= 0; m_ok <= 0; m_err <= 0; m_irq <= 0;
        end else begin
            m_idle <= 0; m_ok <= 0; m_err <= 0; m_irq <= 0;
            if (host_we) mm[host_waddr] <= host_wdata;
            if (ms == 0) begin
                if (base_we) mcur <= base_idx;
                if (tx_enable) ms <= 1;
            end else if (ms == 1) begin
                if (!mm[{mcur, 2'd1}][31]) begin
                    ms <= 0; m_idle <= 1;
                end else begin
                    mcmd  <= mm[{mcur, 2'd1}];
                    maddr <= mm[{mcur, 2'd2}];
                    mnext <= mm[{mcur, 2'd0}][3:0];
                    ms    <= 2;
                end
            end else if (sink_done) begin
                mm[{mcur, 2'd1}] <= wb(mcmd, sink_flags, sink_coll);
                m_ok  <= sink_flags[7];
                m_err <= |(sink_flags & 8'h77);
                m_irq <= mcmd[29];
                mcur  <= mnext;
                ms    <= 1;
            end
        end
    end

    always @(negedge clk) begin
        if (running) begin
            check(busy == (ms != 0), "R2 busy", 32'(busy), 32'(ms != 0));
            check(pkt_valid == (ms == 2), "R3 pkt_valid", 32'(pkt_valid), 32'(ms == 2));
            if (ms == 2) begin
                check(pkt_addr == maddr, "R3/R5/R9 pkt_addr", pkt_addr, maddr);
                check(pkt_len == mcmd[11:0], "R3 pkt_len", 32'(pkt_len), 32'(mcmd[11:0]));
                check(pkt_more == mcmd[30], "R3 pkt_more", 32'(pkt_more), 32'(mcmd[30]));
            end
            check(tx_idle == m_idle, "R6 tx_idle", 32'(tx_idle), 32'(m_idle));
            check(tx_ok == m_ok, "R8 tx_ok", 32'(tx_ok), 32'(m_ok));
            check(tx_err == m_err, "R8 tx_err", 32'(tx_err), 32'(m_err));
            check(irq_desc == m_irq, "R7 irq_desc", 32'(irq_desc), 32'(m_irq));
        end
    end

    // ---------------- host tasks ----------------
    task automatic hw(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); host_we = 1'b1; host_waddr = a; host_wdata = d;
        @(negedge clk); host_we = 1'b0;
    endtask

    task automatic put_desc(input logic [3:0] i, input logic [3:0] lnk, input logic [31:0] c,
                            input logic [31:0] b, input logic [31:0] sw);
        hw({i, 2'd0}, 32'(lnk));
        hw({i, 2'd1}, c);
        hw({i, 2'd2}, b);
        hw({i, 2'd3}, sw);
    endtask

    task automatic kick();
        @(negedge clk); tx_enable = 1'b1;
        @(negedge clk); tx_enable = 1'b0;
    endtask

    task automatic load_base(input logic [3:0] i);
        @(negedge clk); base_we = 1'b1; base_idx = i;
        @(negedge clk); base_we = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        bit seen = 0;
        for (int k = 0; k < 500 && !seen; k++) begin
            @(negedge clk);
            #1;
            if (tx_idle) seen = 1;
        end
        check(seen, tag, 32'(seen), 32'd1);
    endtask

    task automatic rd_check(input logic [5:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); host_raddr = a;
        #1;
        check(host_rdata == exp, tag, host_rdata, exp);
    endtask

    task automatic set_rsp(input int i, input logic [7:0] f, input logic [3:0] k, input int l);
        rsp_flags[i] = f; rsp_coll[i] = k; rsp_lat[i] = l;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) set_rsp(i, 8'h80, 4'h0, 1);
        repeat (3) @(negedge clk);
        check(!busy && !pkt_valid && !tx_idle && !tx_ok && !tx_err && !irq_desc, "R1 reset outputs",
              {26'd0, busy, pkt_valid, tx_idle, tx_ok, tx_err, irq_desc}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !pkt_valid, "R1 after reset", {30'd0, busy, pkt_valid}, 32'd0);
        running = 1'b1;

        // ring 0->1->2->3->0, descriptor 3 not owned
        put_desc(4'd0, 4'd1, 32'hA000_003C, 32'h1000_0000, 32'hDEAD_0000);
        put_desc(4'd1, 4'd2, 32'hC000_05EA, 32'h1000_1000, 32'hDEAD_0001);
        put_desc(4'd2, 4'd3, 32'hB000_0064, 32'h1000_2000, 32'hDEAD_0002);
        put_desc(4'd3, 4'd0, 32'h0000_0040, 32'h1000_3000, 32'hDEAD_0003);
        set_rsp(0, 8'h80, 4'd0, 2);
        set_rsp(1, 8'h88, 4'd3, 0);
        set_rsp(2, 8'h42, 4'd15, 5);
        load_base(4'd0);
        kick();
        wait_idle("R6 first walk stops");
        rd_check(6'd1, wb(32'hA000_003C, 8'h80, 4'd0), "R4 desc0 status");
        rd_check(6'd5, wb(32'hC000_05EA, 8'h88, 4'd3), "R4 desc1 status");
        rd_check(6'd9, wb(32'hB000_0064, 8'h42, 4'd15), "R4 desc2 status");
        rd_check(6'd13, 32'h0000_0040, "R10 unowned desc3 untouched");
        rd_check(6'd3, 32'hDEAD_0000, "R10 software word kept");
        rd_check(6'd0, 32'd1, "R10 link word kept");
        rd_check(6'd6, 32'h1000_1000, "R10 buffer word kept");

        // restart with nothing new: immediate stop on desc3
        kick();
        wait_idle("R6 restart refetches unowned");

        // give desc3 and desc0: wraps 3->0, stops at 1; strobes while busy ignored
        hw(6'd13, 32'h8000_0080);
        hw(6'd1,  32'hE000_0010);
        set_rsp(3, 8'h08, 4'd1, 6);
        set_rsp(4, 8'h20, 4'd0, 1);
        kick();
        repeat (3) @(negedge clk);
        tx_enable = 1'b1; base_we = 1'b1; base_idx = 4'd9;
        @(negedge clk);
        tx_enable = 1'b0; base_we = 1'b0;
        wait_idle("R5 wrap walk stops");
        rd_check(6'd13, wb(32'h8000_0080, 8'h08, 4'd1), "R4/R8 deferred-only status");
        rd_check(6'd1, wb(32'hE000_0010, 8'h20, 4'd0), "R5 wrapped desc0 status");

        // base load while busy was ignored: resume at desc1
        hw(6'd5, 32'h8000_0020);
        set_rsp(5, 8'h80, 4'd2, 0);
        kick();
        wait_idle("R9 resume walk stops");
        rd_check(6'd5, wb(32'h8000_0020, 8'h80, 4'd2), "R9 resumed at desc1");

        // explicit base load to desc2, ok and abort together
        hw(6'd9, 32'hA000_0011);
        set_rsp(6, 8'hC0, 4'd7, 3);
        load_base(4'd2);
        kick();
        wait_idle("R2 base walk stops");
        rd_check(6'd9, wb(32'hA000_0011, 8'hC0, 4'd7), "R2/R8 desc2 ok+abort");
        check(rptr == 7, "R3 descriptors sent", 32'(rptr), 32'd7);

        repeat (3) @(negedge clk);
        running = 1'b0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R6 watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule